// File: doc/BRIEF.md
# Reset Cause Flag Register

This block remembers why the system last went through reset. Seven single-cycle event strobes arrive from the reset controller: external pin, power-on, illegal instruction, watchdog, clock monitor, illegal memory access and low voltage. Each strobe updates a small set of flags by its own rule. Some flags are cleared, some are set and the rest keep their value. Software reads the four cause flags as one status field, and a read strobe clears that field on the next clock edge.

The block also holds the control and level registers of a low-voltage detector. Most reset sources send the detector enable bit and the detection level back to a default. A low-voltage reset leaves them alone, so the detector keeps running across the reset it caused. A two-bit option input picks the default level. When no reset strobe is active, software may write the detector fields.

Top module: `rst_cause_reg`

## Requirements
- R1: After rst_ni is released, cause_o is 0, por_flag_o is 1, clkmon_flag_o is 0, det_ctrl_o is 0 and det_lvl_o is 8'h00.
- R2: A pin_rst_i or por_rst_i strobe clears all four cause bits and clkmon_flag_o on the next edge.
- R3: cause_o bit 0 is set by ill_insn_rst_i, bit 1 by wdog_rst_i, bit 2 by ill_mem_rst_i and bit 3 by lowv_rst_i. Each of these strobes sets only its own bit and leaves the other bits unchanged. A clkmon_rst_i strobe changes no cause bit. Strobes that arrive together all apply.
- R4: stat_rd_i clears cause_o on the next edge. During the read cycle, cause_o still shows the value from before the clear.
- R5: If stat_rd_i and a cause-setting strobe arrive in the same cycle, the newly set bits read 1 afterwards and all other cause bits read 0.
- R6: por_flag_o is cleared only by por_rst_i. No other strobe and no read changes it.
- R7: clkmon_rst_i sets clkmon_flag_o unless pin_rst_i or por_rst_i is active in the same cycle. No other strobe and no read changes it.
- R8: det_ctrl_o bit 0 (enable) is cleared by any strobe other than lowv_rst_i, including when lowv_rst_i arrives with another strobe. lowv_rst_i alone, and a read, leave it unchanged.
- R9: det_ctrl_o bits 1 (mask) and 2 (flag) are never changed by any reset strobe. A software write that arrives in the same cycle as any strobe is dropped.
- R10: On any strobe other than lowv_rst_i alone, det_lvl_o is loaded with a value chosen by lvl_opt_i: 2'b10 gives 8'h00, 2'b11 gives 8'h81, 2'b01 gives 8'h01 and the reserved 2'b00 gives 8'h00. lowv_rst_i alone, and a read, leave it unchanged.
- R11: When no strobe is active, det_wr_i loads det_wdata_i[2:0] into det_ctrl_o and lvl_wr_i loads lvl_wdata_i into det_lvl_o on the next edge.
- R12: por_rst_i and pin_rst_i take priority over every other strobe. Cause strobes and the clock-monitor strobe that arrive with either of them have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low register initialisation |
| pin_rst_i | input | 1 | External pin reset strobe |
| por_rst_i | input | 1 | Power-on reset strobe |
| ill_insn_rst_i | input | 1 | Illegal instruction reset strobe |
| wdog_rst_i | input | 1 | Watchdog reset strobe |
| clkmon_rst_i | input | 1 | Clock monitor reset strobe |
| ill_mem_rst_i | input | 1 | Illegal memory access reset strobe |
| lowv_rst_i | input | 1 | Low-voltage reset strobe |
| lvl_opt_i | input | 2 | Option that selects the default detector level |
| stat_rd_i | input | 1 | Status read strobe (clear on read) |
| det_wr_i | input | 1 | Software write strobe for the detector control bits |
| det_wdata_i | input | 3 | Write data {flag, mask, enable} |
| lvl_wr_i | input | 1 | Software write strobe for the detector level |
| lvl_wdata_i | input | 8 | Detector level write data |
| cause_o | output | 4 | Cause flags {lowv, ill_mem, wdog, ill_insn} |
| por_flag_o | output | 1 | Power-on indicator flag |
| clkmon_flag_o | output | 1 | Clock monitor reset flag |
| det_ctrl_o | output | 3 | Detector control {flag, mask, enable} |
| det_lvl_o | output | 8 | Detector level register |

## Verification
Two kinds of event can collide here. A status read can meet a cause-setting strobe in the same cycle. A low-voltage strobe can meet another reset source, which decides whether the detector fields are held or reset. Directed cycles drive each pair at the same clock edge and check the exact result on the following cycle. A long weighted-random run then mixes reads, writes and strobes, often several in one cycle. A behavioural model built from the requirements is compared against every output on every clock.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int unsigned NUM_CAUSE = 4;
  localparam int unsigned CTRL_W    = 3;

  // cause bit positions
  localparam int unsigned C_ILL_INSN = 0;
  localparam int unsigned C_WDOG     = 1;
  localparam int unsigned C_ILL_MEM  = 2;
  localparam int unsigned C_LOWV     = 3;

  // detector control bit positions
  localparam int unsigned D_EN   = 0;
  localparam int unsigned D_MASK = 1;
  localparam int unsigned D_FLAG = 2;

  typedef struct packed {
    logic                 hard_clr;   // pin or power-on
    logic                 por_clr;
    logic                 clkmon_set;
    logic [NUM_CAUSE-1:0] cause_set;
    logic                 det_dflt;   // any source other than lone low-voltage
    logic                 any;
  } rst_evt_t;
endpackage

// File: rtl/rst_event_dec.sv
module rst_event_dec
  import rst_cause_pkg::*;
(
  input  logic     pin_i,
  input  logic     por_i,
  input  logic     ill_insn_i,
  input  logic     wdog_i,
  input  logic     clkmon_i,
  input  logic     ill_mem_i,
  input  logic     lowv_i,
  output rst_evt_t evt_o
);
  logic [NUM_CAUSE-1:0] raw;
  logic                 hard;

  always_comb begin
    raw             = '0;
    raw[C_ILL_INSN] = ill_insn_i;
    raw[C_WDOG]     = wdog_i;
    raw[C_ILL_MEM]  = ill_mem_i;
    raw[C_LOWV]     = lowv_i;
  end

  assign hard = pin_i | por_i;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CAUSE; gi++) begin : g_set
      assign evt_o.cause_set[gi] = raw[gi] & ~hard;
    end
  endgenerate

  assign evt_o.hard_clr   = hard;
  assign evt_o.por_clr    = por_i;
  assign evt_o.clkmon_set = clkmon_i & ~hard;
  assign evt_o.det_dflt   = hard | ill_insn_i | wdog_i | ill_mem_i | clkmon_i;
  assign evt_o.any        = hard | (|raw) | clkmon_i;
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rst_cause_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  rst_evt_t             evt_i,
  input  logic                 rd_i,
  output logic [NUM_CAUSE-1:0] cause_o,
  output logic                 por_flag_o,
  output logic                 clkmon_flag_o
);
  logic [NUM_CAUSE-1:0] cause_q;
  logic                 por_q;
  logic                 clkmon_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CAUSE; gi++) begin : g_cause
      // set beats read-clear so no cause is lost
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  cause_q[gi] <= 1'b0;
        else if (evt_i.hard_clr)      cause_q[gi] <= 1'b0;
        else if (evt_i.cause_set[gi]) cause_q[gi] <= 1'b1;
        else if (rd_i)                cause_q[gi] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           por_q <= 1'b1;
    else if (evt_i.por_clr) por_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              clkmon_q <= 1'b0;
    else if (evt_i.hard_clr)  clkmon_q <= 1'b0;
    else if (evt_i.clkmon_set) clkmon_q <= 1'b1;
  end

  assign cause_o       = cause_q;
  assign por_flag_o    = por_q;
  assign clkmon_flag_o = clkmon_q;

  // R2
  hard_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.hard_clr |=> (cause_q == '0) && !clkmon_q);
  // R4
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !evt_i.any) |=> (cause_q == '0));
  // R5
  rd_set_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !evt_i.hard_clr && (evt_i.cause_set != '0)) |=> (cause_q == $past(evt_i.cause_set)));
  // R6
  por_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i.por_clr |=> $stable(por_q));
  // R7
  clkmon_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.clkmon_set |=> clkmon_q);
endmodule

// File: rtl/rst_lvd_regs.sv
module rst_lvd_regs
  import rst_cause_pkg::*;
#(
  parameter int unsigned      LVL_W    = 8,
  parameter logic [LVL_W-1:0] LVL_OPT0 = 8'h00,
  parameter logic [LVL_W-1:0] LVL_OPT1 = 8'h01,
  parameter logic [LVL_W-1:0] LVL_OPT2 = 8'h00,
  parameter logic [LVL_W-1:0] LVL_OPT3 = 8'h81
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rst_evt_t          evt_i,
  input  logic [1:0]        opt_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              lvl_wr_i,
  input  logic [LVL_W-1:0]  lvl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [LVL_W-1:0]  lvl_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [LVL_W-1:0]  lvl_dflt;
  logic              sw_ok;

  always_comb begin
    unique case (opt_i)
      2'b01:   lvl_dflt = LVL_OPT1;
      2'b10:   lvl_dflt = LVL_OPT2;
      2'b11:   lvl_dflt = LVL_OPT3;
      default: lvl_dflt = LVL_OPT0;
    endcase
  end

  assign sw_ok = ~evt_i.any;

  genvar gi;
  generate
    for (gi = 0; gi < CTRL_W; gi++) begin : g_ctrl
      if (gi == D_EN) begin : g_en
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)                ctrl_q[gi] <= 1'b0;
          else if (evt_i.det_dflt)    ctrl_q[gi] <= 1'b0;
          else if (sw_ok && ctrl_wr_i) ctrl_q[gi] <= ctrl_wdata_i[gi];
        end
      end else begin : g_keep
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)                ctrl_q[gi] <= 1'b0;
          else if (sw_ok && ctrl_wr_i) ctrl_q[gi] <= ctrl_wdata_i[gi];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lvl_q <= '0;
    else if (evt_i.det_dflt)    lvl_q <= lvl_dflt;
    else if (sw_ok && lvl_wr_i) lvl_q <= lvl_wdata_i;
  end

  assign ctrl_o = ctrl_q;
  assign lvl_o  = lvl_q;

  // R8
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.det_dflt |=> !ctrl_q[D_EN]);
  // R9
  mask_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.any |=> $stable(ctrl_q[D_MASK]) && $stable(ctrl_q[D_FLAG]));
  // R10
  lvl_lowv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.any && !evt_i.det_dflt) |=> $stable(lvl_q) && $stable(ctrl_q));
  // R11
  lvl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_ok && lvl_wr_i) |=> (lvl_q == $past(lvl_wdata_i)));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pin_rst_i,
  input  logic                 por_rst_i,
  input  logic                 ill_insn_rst_i,
  input  logic                 wdog_rst_i,
  input  logic                 clkmon_rst_i,
  input  logic                 ill_mem_rst_i,
  input  logic                 lowv_rst_i,
  input  logic [1:0]           lvl_opt_i,
  input  logic                 stat_rd_i,
  input  logic                 det_wr_i,
  input  logic [CTRL_W-1:0]    det_wdata_i,
  input  logic                 lvl_wr_i,
  input  logic [LVL_W-1:0]     lvl_wdata_i,
  output logic [NUM_CAUSE-1:0] cause_o,
  output logic                 por_flag_o,
  output logic                 clkmon_flag_o,
  output logic [CTRL_W-1:0]    det_ctrl_o,
  output logic [LVL_W-1:0]     det_lvl_o
);
  rst_evt_t evt;

  rst_event_dec u_dec (
    .pin_i      (pin_rst_i),
    .por_i      (por_rst_i),
    .ill_insn_i (ill_insn_rst_i),
    .wdog_i     (wdog_rst_i),
    .clkmon_i   (clkmon_rst_i),
    .ill_mem_i  (ill_mem_rst_i),
    .lowv_i     (lowv_rst_i),
    .evt_o      (evt)
  );

  rst_cause_flags u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .evt_i         (evt),
    .rd_i          (stat_rd_i),
    .cause_o       (cause_o),
    .por_flag_o    (por_flag_o),
    .clkmon_flag_o (clkmon_flag_o)
  );

  rst_lvd_regs #(
    .LVL_W    (LVL_W),
    .LVL_OPT0 (LVL_W'(8'h00)),
    .LVL_OPT1 (LVL_W'(8'h01)),
    .LVL_OPT2 (LVL_W'(8'h00)),
    .LVL_OPT3 (LVL_W'(8'h81))
  ) u_lvd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt),
    .opt_i        (lvl_opt_i),
    .ctrl_wr_i    (det_wr_i),
    .ctrl_wdata_i (det_wdata_i),
    .lvl_wr_i     (lvl_wr_i),
    .lvl_wdata_i  (lvl_wdata_i),
    .ctrl_o       (det_ctrl_o),
    .lvl_o        (det_lvl_o)
  );

  // R3
  wdog_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_rst_i && !pin_rst_i && !por_rst_i) |=> cause_o[C_WDOG]);
  // R12
  por_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_rst_i |=> (cause_o == '0) && !clkmon_flag_o && !por_flag_o);
endmodule

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 0, por = 0, ili = 0, wdg = 0, cmon = 0, ilm = 0, lowv = 0;
  logic [1:0] opt = 2'b10;
  logic       rd = 0, dwr = 0, lwr = 0;
  logic [2:0] dwd = 0;
  logic [7:0] lwd = 0;
  logic [3:0] cause;
  logic       porf, cmf;
  logic [2:0] ctrl;
  logic [7:0] lvl;

  int n_chk = 0, n_fail = 0;

  // reference state
  logic [3:0] m_cause;
  logic       m_por, m_cm;
  logic [2:0] m_ctrl;
  logic [7:0] m_lvl;

  always #4 clk = ~clk;

  rst_cause_reg u_rst_cause_reg (
    .clk_i(clk), .rst_ni(rst_n),
    .pin_rst_i(pin), .por_rst_i(por), .ill_insn_rst_i(ili), .wdog_rst_i(wdg),
    .clkmon_rst_i(cmon), .ill_mem_rst_i(ilm), .lowv_rst_i(lowv),
    .lvl_opt_i(opt), .stat_rd_i(rd), .det_wr_i(dwr), .det_wdata_i(dwd),
    .lvl_wr_i(lwr), .lvl_wdata_i(lwd),
    .cause_o(cause), .por_flag_o(porf), .clkmon_flag_o(cmf),
    .det_ctrl_o(ctrl), .det_lvl_o(lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [1:0] o);
    case (o)
      2'b01: return 8'h01;
      2'b11: return 8'h81;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    bit hard = pin | por;
    bit other = ili | wdg | cmon | ilm;
    bit anyev = hard | other | lowv;
    logic [3:0] setv = hard ? 4'b0 : {lowv, ilm, wdg, ili};
    if (hard) m_cause = 4'b0;
    else m_cause = (rd ? 4'b0 : m_cause) | setv;
    if (por) m_por = 1'b0;
    if (hard) m_cm = 1'b0;
    else if (cmon) m_cm = 1'b1;
    if (!anyev && dwr) m_ctrl = dwd;
    if (hard || other) begin
      m_ctrl[0] = 1'b0;
      m_lvl = dflt(opt);
    end else if (!anyev && lwr) m_lvl = lwd;
  endtask

  task automatic cmp_all();
    chk("R3 cause", cause, m_cause);
    chk("R6 por_flag", porf, m_por);
    chk("R7 clkmon_flag", cmf, m_cm);
    chk("R8 enable", ctrl[0], m_ctrl[0]);
    chk("R9 mask/flag", ctrl[2:1], m_ctrl[2:1]);
    chk("R10 level", lvl, m_lvl);
  endtask

  // inputs are driven at negedge; one full cycle then compare at next negedge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle();
    {pin, por, ili, wdg, cmon, ilm, lowv, rd, dwr, lwr} = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    m_cause = 0; m_por = 1; m_cm = 0; m_ctrl = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cause", cause, 0);
    chk("R1 por_flag", porf, 1);
    chk("R1 clkmon", cmf, 0);
    chk("R1 ctrl", ctrl, 0);
    chk("R1 level", lvl, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 software writes
    dwr = 1; dwd = 3'b111; lwr = 1; lwd = 8'h5a; tick(); idle();
    chk("R11 ctrl write", ctrl, 3'b111);
    chk("R11 level write", lvl, 8'h5a);

    // R3 watchdog sets own bit only; R8 enable cleared; R9 mask/flag held; R10 opt 10 -> 00
    wdg = 1; tick(); idle();
    chk("R3 wdog bit1", cause, 4'b0010);
    chk("R8 enable cleared", ctrl, 3'b110);
    chk("R10 opt10 level", lvl, 8'h00);

    // R8/R10 low-voltage alone holds enable and level
    dwr = 1; dwd = 3'b001; lwr = 1; lwd = 8'h33; tick(); idle();
    lowv = 1; dwr = 1; dwd = 3'b110; tick(); idle();
    chk("R3 lowv bit3 added", cause, 4'b1010);
    chk("R8 lowv holds enable", ctrl[0], 1);
    chk("R9 write dropped in reset cycle", ctrl, 3'b001);
    chk("R10 lowv holds level", lvl, 8'h33);

    // R4 read returns old value then clears
    rd = 1; #1;
    chk("R4 pre-clear value", cause, 4'b1010);
    tick(); idle();
    chk("R4 cleared after read", cause, 0);

    // R5 read with set in same cycle
    ili = 1; tick(); idle();
    rd = 1; ilm = 1; tick(); idle();
    chk("R5 new set survives read", cause, 4'b0100);

    // R8 lowv with another source clears enable; R10 opt 11 -> 81
    dwr = 1; dwd = 3'b001; tick(); idle();
    opt = 2'b11; lowv = 1; cmon = 1; tick(); idle();
    chk("R8 lowv+cmon clears enable", ctrl[0], 0);
    chk("R10 opt11 level", lvl, 8'h81);
    chk("R7 clkmon set", cmf, 1);
    opt = 2'b01; ili = 1; tick(); idle();
    chk("R10 opt01 level", lvl, 8'h01);
    opt = 2'b00; wdg = 1; tick(); idle();
    chk("R10 opt00 reserved level", lvl, 8'h00);

    // R2 pin clears causes and clkmon, R6 pin keeps por flag
    pin = 1; tick(); idle();
    chk("R2 pin clears causes", cause, 0);
    chk("R2 pin clears clkmon", cmf, 0);
    chk("R6 pin keeps por flag", porf, 1);

    // R12 por wins over other sources
    por = 1; wdg = 1; cmon = 1; lowv = 1; tick(); idle();
    chk("R12 por beats causes", cause, 0);
    chk("R12 por beats clkmon", cmf, 0);
    chk("R6 por clears flag", porf, 0);

    // random mix compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      pin  = ($urandom_range(0, 39) == 0);
      por  = ($urandom_range(0, 79) == 0);
      ili  = ($urandom_range(0, 9) == 0);
      wdg  = ($urandom_range(0, 9) == 0);
      cmon = ($urandom_range(0, 11) == 0);
      ilm  = ($urandom_range(0, 9) == 0);
      lowv = ($urandom_range(0, 7) == 0);
      rd   = ($urandom_range(0, 3) == 0);
      dwr  = ($urandom_range(0, 3) == 0);
      lwr  = ($urandom_range(0, 3) == 0);
      dwd  = 3'($urandom);
      lwd  = 8'($urandom);
      if ($urandom_range(0, 49) == 0) opt = 2'($urandom);
      tick();
    end
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule